// File: doc/BRIEF.md
# Serial Row-Programming Command Sequencer

This block is the host side of a two-wire serial programming link. One wire carries a clock and the other carries data. The block writes one full row of a target's code memory per start request. The host supplies a 24-bit destination address and a pulse on `start`. It then streams the row's 24-bit instruction words through a valid/ready port. The sequencer turns this into a fixed series of serial frames. Each frame is a 4-bit command code followed by a 24-bit payload that the target executes.

For every block of four words, the sequencer emits the following frames, in this order:
- six move-immediate frames that carry the words packed into 16-bit halves;
- one frame that clears the latch read pointer;
- eight table-write frames that copy the packed registers into the row latches.

The row begins with a fixed preamble that leaves the reset vector and selects row-write mode, followed by the address load. After the last block come the commit frames and a jump back to 0x200, which parks the target's program counter. A one-cycle `done` pulse ends the row.

Top module: `rowprog_seq`

## Requirements
- R1: Every frame is 28 bits: command code 0000 in the first four bits, then the 24-bit payload, all shifted least significant bit first. A new frame never starts while the previous one is still shifting.
- R2: `prog_clk` idles low. Each high phase lasts exactly CLK_DIV system cycles, and each low phase lasts at least CLK_DIV cycles. `prog_dat` changes only while `prog_clk` is low and holds steady through each high phase.
- R3: A row opens with five frames carrying payloads 000000, 040200, 000000, 24001A and 883B0A.
- R4: Three address frames follow. The first is a move-immediate {4'h2, 8'h00, addr[23:16], 4'h0}. The second is 880190. The third is a move-immediate {4'h2, addr[15:0], 4'h7}.
- R5: For each block of four words w0..w3, six frames {4'h2, Rk, k} are sent for k = 0..5, where:
  - R0 = w0[15:0]
  - R1 = {w1[23:16], w0[23:16]}
  - R2 = w1[15:0]
  - R3 = w2[15:0]
  - R4 = {w3[23:16], w2[23:16]}
  - R5 = w3[15:0]
- R6: After the six moves of a block come the pointer-clear frame EB0300 and then eight table-write frames, in this order: BB0B36, BBDBB6, BBEBB6, BB1BB6, BB0BB6, BBDBB6, BBEBB6, BB1BB6. The table-write order restarts with every block.
- R7: A row takes ROW_WORDS/4 blocks (16 by default) and accepts exactly ROW_WORDS words, for 253 frames in total with the defaults.
- R8: After the last block come the commit frames A8E761, 000000, 000000, then the program-counter reset frames 040200 and 000000.
- R9: `word_ready` is high only while the sequencer is gathering a block and holds fewer than four words. It is never high while a frame is shifting.
- R10: `done` is a single-cycle pulse one cycle after the final frame finishes, after which `busy` is low. A `start` received while `busy` is high is ignored, and the row under way is unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a row (sampled only while idle) |
| start_addr | input | 24 | Row destination address |
| word_valid | input | 1 | Instruction word offered |
| word_data | input | 24 | Instruction word |
| word_ready | output | 1 | Word accepted when high with `word_valid` |
| prog_clk | output | 1 | Serial programming clock |
| prog_dat | output | 1 | Serial programming data |
| busy | output | 1 | Row in progress |
| done | output | 1 | One-cycle end-of-row pulse |

## Verification
The hardest case to reach is an interaction between the host and the block in the middle of a row. This covers a source that stalls between words, so the sequencer has to wait partway through filling a block. It also covers a second start request arriving while frames are already shifting. The bench reaches this with a row in which `word_valid` drops every third cycle, and a start pulse with a different address injected thousands of cycles into that row. Every decoded frame of that row must still match the list computed from the first address.

// File: rtl/rowprog_pkg.sv
package rowprog_pkg;
  localparam int CMD_W   = 4;
  localparam int PAY_W   = 24;
  localparam int FRAME_W = CMD_W + PAY_W;

  typedef logic [PAY_W-1:0] payload_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PRO, ST_ADDR, ST_GATHER, ST_GRP, ST_COMMIT, ST_PCRST
  } seq_state_t;

  localparam payload_t PL_NOP    = 24'h000000;
  localparam payload_t PL_GOTO   = 24'h040200;
  localparam payload_t PL_MODE   = 24'h24001A;
  localparam payload_t PL_MODEMV = 24'h883B0A;
  localparam payload_t PL_PAGEMV = 24'h880190;
  localparam payload_t PL_PTRCLR = 24'hEB0300;
  localparam payload_t PL_COMMIT = 24'hA8E761;

  function automatic payload_t mov_imm(input logic [15:0] lit, input logic [3:0] rnum);
    return {4'h2, lit, rnum};
  endfunction

  function automatic logic [15:0] pack_reg(input logic [3:0][23:0] w, input int k);
    case (k)
      0:       return w[0][15:0];
      1:       return {w[1][23:16], w[0][23:16]};
      2:       return w[1][15:0];
      3:       return w[2][15:0];
      4:       return {w[3][23:16], w[2][23:16]};
      default: return w[3][15:0];
    endcase
  endfunction

  function automatic payload_t tblwt_rom(input logic [2:0] i);
    case (i)
      3'd0, 3'd4: return 24'hBB0B36 | (i[2] ? 24'h000080 : 24'h0);
      3'd1, 3'd5: return 24'hBBDBB6;
      3'd2, 3'd6: return 24'hBBEBB6;
      default:    return 24'hBB1BB6;
    endcase
  endfunction
endpackage

// File: rtl/rowprog_shifter.sv
module rowprog_shifter
  import rowprog_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     load,
  input  payload_t payload,
  output logic     busy,
  output logic     frame_done,
  output logic     sclk,
  output logic     sdat
);
  localparam int DIV_W = (CLK_DIV > 1) ? $clog2(CLK_DIV) : 1;
  localparam int BIT_W = $clog2(FRAME_W);
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(CLK_DIV - 1);
  localparam logic [BIT_W-1:0] BIT_LAST = BIT_W'(FRAME_W - 1);

  logic [FRAME_W-1:0] sh_q, sh_d;
  logic [BIT_W-1:0]   bit_q, bit_d;
  logic [DIV_W-1:0]   div_q, div_d;
  logic               ph_q, ph_d, busy_q, busy_d, tick;

  always_comb begin
    sh_d = sh_q; bit_d = bit_q; div_d = div_q; ph_d = ph_q; busy_d = busy_q;
    frame_done = 1'b0;
    tick = busy_q && (div_q == DIV_LAST);
    if (load) begin
      sh_d   = {payload, {CMD_W{1'b0}}};
      bit_d  = '0;
      div_d  = '0;
      ph_d   = 1'b0;
      busy_d = 1'b1;
    end else if (busy_q) begin
      if (tick) begin
        div_d = '0;
        if (!ph_q) begin
          ph_d = 1'b1;
        end else begin
          ph_d = 1'b0;
          if (bit_q == BIT_LAST) begin
            busy_d     = 1'b0;
            frame_done = 1'b1;
          end else begin
            sh_d  = sh_q >> 1;
            bit_d = bit_q + 1'b1;
          end
        end
      end else begin
        div_d = div_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q <= '0; bit_q <= '0; div_q <= '0; ph_q <= 1'b0; busy_q <= 1'b0;
    end else begin
      sh_q <= sh_d; bit_q <= bit_d; div_q <= div_d; ph_q <= ph_d; busy_q <= busy_d;
    end
  end

  assign busy = busy_q;
  assign sclk = ph_q;
  assign sdat = busy_q & sh_q[0];

  assert_hold_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk && $past(sclk)) |-> $stable(sdat));
  assert_load_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !busy_q);
endmodule

// File: rtl/rowprog_packer.sv
module rowprog_packer
  import rowprog_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             collect,
  input  logic             clear,
  input  logic             in_valid,
  input  logic [23:0]      in_data,
  output logic             in_ready,
  output logic             full,
  output logic [5:0][15:0] regs
);
  localparam int SLOTS = 4;

  logic [2:0]       cnt_q, cnt_d;
  logic [3:0][23:0] words_q;
  logic             accept;

  assign full     = (cnt_q == 3'(SLOTS));
  assign in_ready = collect && !full;
  assign accept   = in_valid && in_ready;

  always_comb begin
    cnt_d = cnt_q;
    if (clear)       cnt_d = '0;
    else if (accept) cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 words_q[s] <= '0;
      else if (accept && (cnt_q == 3'(s)))        words_q[s] <= in_data;
    end
  end

  for (genvar k = 0; k < 6; k++) begin : g_pack
    assign regs[k] = pack_reg(words_q, k);
  end

  assert_count_bound_R9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= 3'(SLOTS));
endmodule

// File: rtl/rowprog_seq.sv
module rowprog_seq
  import rowprog_pkg::*;
#(
  parameter int ROW_WORDS = 64,
  parameter int CLK_DIV   = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [23:0] start_addr,
  input  logic        word_valid,
  input  logic [23:0] word_data,
  output logic        word_ready,
  output logic        prog_clk,
  output logic        prog_dat,
  output logic        busy,
  output logic        done
);
  localparam int NGRP  = ROW_WORDS / 4;
  localparam int GRP_W = (NGRP > 1) ? $clog2(NGRP) : 1;
  localparam logic [GRP_W-1:0] GRP_LAST = GRP_W'(NGRP - 1);
  localparam logic [3:0] GRP_STEPS_LAST = 4'd14;
  localparam logic [3:0] FIRST_TBL      = 4'd7;

  seq_state_t       state_q, state_d;
  logic [3:0]       idx_q, idx_d, last_idx;
  logic [GRP_W-1:0] grp_q, grp_d;
  logic [2:0]       tbl_q, tbl_d;
  logic [23:0]      addr_q, addr_d;
  logic             done_q, done_d;
  logic             emitting, sh_load, sh_busy, sh_done, pk_full, pk_clear;
  logic [5:0][15:0] pk_regs;
  payload_t         payload;

  rowprog_packer u_packer (
    .clk(clk), .rst_n(rst_n), .collect(state_q == ST_GATHER), .clear(pk_clear),
    .in_valid(word_valid), .in_data(word_data), .in_ready(word_ready),
    .full(pk_full), .regs(pk_regs)
  );

  rowprog_shifter #(.CLK_DIV(CLK_DIV)) u_shifter (
    .clk(clk), .rst_n(rst_n), .load(sh_load), .payload(payload),
    .busy(sh_busy), .frame_done(sh_done), .sclk(prog_clk), .sdat(prog_dat)
  );

  always_comb begin
    payload  = PL_NOP;
    last_idx = 4'd0;
    case (state_q)
      ST_PRO: begin
        last_idx = 4'd4;
        case (idx_q)
          4'd1:    payload = PL_GOTO;
          4'd3:    payload = PL_MODE;
          4'd4:    payload = PL_MODEMV;
          default: payload = PL_NOP;
        endcase
      end
      ST_ADDR: begin
        last_idx = 4'd2;
        case (idx_q)
          4'd0:    payload = mov_imm({8'h00, addr_q[23:16]}, 4'h0);
          4'd1:    payload = PL_PAGEMV;
          default: payload = mov_imm(addr_q[15:0], 4'h7);
        endcase
      end
      ST_GRP: begin
        last_idx = GRP_STEPS_LAST;
        if (idx_q < 4'd6)           payload = mov_imm(pk_regs[idx_q[2:0]], idx_q);
        else if (idx_q == 4'd6)     payload = PL_PTRCLR;
        else                        payload = tblwt_rom(tbl_q);
      end
      ST_COMMIT: begin
        last_idx = 4'd2;
        payload  = (idx_q == 4'd0) ? PL_COMMIT : PL_NOP;
      end
      ST_PCRST: begin
        last_idx = 4'd1;
        payload  = (idx_q == 4'd0) ? PL_GOTO : PL_NOP;
      end
      default: ;
    endcase
  end

  assign emitting = (state_q == ST_PRO) || (state_q == ST_ADDR) || (state_q == ST_GRP) ||
                    (state_q == ST_COMMIT) || (state_q == ST_PCRST);
  assign sh_load  = emitting && !sh_busy;
  assign pk_clear = (state_q == ST_GRP) && sh_done && (idx_q == GRP_STEPS_LAST);

  always_comb begin
    state_d = state_q; idx_d = idx_q; grp_d = grp_q; tbl_d = tbl_q;
    addr_d  = addr_q;  done_d = 1'b0;
    case (state_q)
      ST_IDLE: if (start) begin
        addr_d = start_addr; state_d = ST_PRO; idx_d = '0; grp_d = '0;
      end
      ST_GATHER: if (pk_full) begin
        state_d = ST_GRP; idx_d = '0; tbl_d = '0;
      end
      default: if (emitting && sh_done) begin
        if (idx_q == last_idx) begin
          idx_d = '0;
          case (state_q)
            ST_PRO:    state_d = ST_ADDR;
            ST_ADDR:   state_d = ST_GATHER;
            ST_GRP: begin
              if (grp_q == GRP_LAST) state_d = ST_COMMIT;
              else begin
                state_d = ST_GATHER; grp_d = grp_q + 1'b1;
              end
            end
            ST_COMMIT: state_d = ST_PCRST;
            default: begin
              state_d = ST_IDLE; done_d = 1'b1;
            end
          endcase
        end else begin
          idx_d = idx_q + 1'b1;
          if ((state_q == ST_GRP) && (idx_q >= FIRST_TBL)) tbl_d = tbl_q + 1'b1;
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE; idx_q <= '0; grp_q <= '0; tbl_q <= '0;
      addr_q  <= '0;      done_q <= 1'b0;
    end else begin
      state_q <= state_d; idx_q <= idx_d; grp_q <= grp_d; tbl_q <= tbl_d;
      addr_q  <= addr_d;  done_q <= done_d;
    end
  end

  assign busy = (state_q != ST_IDLE);
  assign done = done_q;

  assert_done_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> $stable(addr_q));
  assert_quiet_shift_R9: assert property (@(posedge clk) disable iff (!rst_n)
    sh_busy |-> !word_ready);
  assert_tbl_restart_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_GRP && idx_q == FIRST_TBL) |-> (tbl_q == 3'd0));
endmodule

// File: tb/rowprog_seq_bench.sv
module rowprog_seq_bench;
  localparam int ROWW   = 64;
  localparam int DIV    = 2;
  localparam int NFR    = 253;
  localparam int WD_MAX = 190000;

  logic clk, rst_n, start, word_valid, word_ready, prog_clk, prog_dat, busy, done;
  logic [23:0] start_addr, word_data;

  rowprog_seq #(.ROW_WORDS(ROWW), .CLK_DIV(DIV)) u_rowprog_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
    .word_valid(word_valid), .word_data(word_data), .word_ready(word_ready),
    .prog_clk(prog_clk), .prog_dat(prog_dat), .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  logic [27:0] rx [0:NFR+7];
  logic [23:0] expq [0:NFR-1];
  logic [23:0] words [0:ROWW-1];
  int rx_cnt, bits, hi_len, width_err, stab_err, ready_err, acc_cnt, done_cnt, done_wide, done_rx;
  logic [27:0] shreg;
  logic prev_sclk, prev_done, hi_dat;

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WD_MAX) begin
      fails++; checks++;
      $display("FAIL watchdog R10 actual=%0d expected=%0d", cyc, WD_MAX);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  always @(negedge clk) begin
    if (!rst_n) begin
      prev_sclk = 1'b0; prev_done = 1'b0;
    end else begin
      if (prog_clk && !prev_sclk) begin
        shreg = {prog_dat, shreg[27:1]}; bits++; hi_len = 1; hi_dat = prog_dat;
        if (bits == 28) begin
          if (rx_cnt < NFR + 8) rx[rx_cnt] = shreg;
          rx_cnt++; bits = 0;
        end
      end else if (prog_clk) begin
        hi_len++;
        if (prog_dat != hi_dat) stab_err++;
      end
      if (!prog_clk && prev_sclk && hi_len != DIV) width_err++;
      if (word_ready && prog_clk) ready_err++;
      if (word_valid && word_ready) acc_cnt++;
      if (done) begin done_cnt++; done_rx = rx_cnt; end
      if (done && prev_done) done_wide++;
      prev_sclk = prog_clk; prev_done = done;
    end
  end

  function automatic logic [23:0] mi(input logic [15:0] lit, input logic [3:0] r);
    return {4'h2, lit, r};
  endfunction

  task automatic build_exp(input logic [23:0] a);
    logic [23:0] tw [0:7];
    tw[0] = 24'hBB0B36; tw[1] = 24'hBBDBB6; tw[2] = 24'hBBEBB6; tw[3] = 24'hBB1BB6;
    tw[4] = 24'hBB0BB6; tw[5] = 24'hBBDBB6; tw[6] = 24'hBBEBB6; tw[7] = 24'hBB1BB6;
    expq[0] = 24'h000000; expq[1] = 24'h040200; expq[2] = 24'h000000;
    expq[3] = 24'h24001A; expq[4] = 24'h883B0A;
    expq[5] = mi({8'h00, a[23:16]}, 4'h0); expq[6] = 24'h880190; expq[7] = mi(a[15:0], 4'h7);
    for (int g = 0; g < ROWW/4; g++) begin
      int b = 8 + g*15;
      logic [23:0] w0, w1, w2, w3;
      w0 = words[4*g]; w1 = words[4*g+1]; w2 = words[4*g+2]; w3 = words[4*g+3];
      expq[b]   = mi(w0[15:0], 4'h0);
      expq[b+1] = mi({w1[23:16], w0[23:16]}, 4'h1);
      expq[b+2] = mi(w1[15:0], 4'h2);
      expq[b+3] = mi(w2[15:0], 4'h3);
      expq[b+4] = mi({w3[23:16], w2[23:16]}, 4'h4);
      expq[b+5] = mi(w3[15:0], 4'h5);
      expq[b+6] = 24'hEB0300;
      for (int t = 0; t < 8; t++) expq[b+7+t] = tw[t];
    end
    expq[248] = 24'hA8E761; expq[249] = 24'h000000; expq[250] = 24'h000000;
    expq[251] = 24'h040200; expq[252] = 24'h000000;
  endtask

  task automatic region(input int lo, input int hi, input string tag);
    int bad = -1;
    for (int i = lo; i <= hi; i++)
      if (bad < 0 && (i >= rx_cnt || rx[i][27:4] != expq[i])) bad = i;
    if (bad < 0) check(1'b1, tag, 0, 0);
    else check(1'b0, tag, (bad < rx_cnt) ? rx[bad][27:4] : 24'hDEAD, expq[bad]);
  endtask

  task automatic grp_region(input int klo, input int khi, input string tag);
    int bad = -1;
    for (int g = 0; g < ROWW/4; g++)
      for (int k = klo; k <= khi; k++) begin
        int i = 8 + g*15 + k;
        if (bad < 0 && (i >= rx_cnt || rx[i][27:4] != expq[i])) bad = i;
      end
    if (bad < 0) check(1'b1, tag, 0, 0);
    else check(1'b0, tag, (bad < rx_cnt) ? rx[bad][27:4] : 24'hDEAD, expq[bad]);
  endtask

  task automatic feed(input bit bubbles);
    int i = 0, k = 0;
    while (i < ROWW) begin
      bit r;
      @(negedge clk);
      if (bubbles && (k % 3 == 2)) begin
        word_valid = 1'b0; r = 1'b0;
      end else begin
        word_valid = 1'b1; word_data = words[i]; r = word_ready;
      end
      k++;
      @(posedge clk);
      if (r) i++;
    end
    @(negedge clk); word_valid = 1'b0;
  endtask

  task automatic run_row(input logic [23:0] a, input int seed, input bit stress);
    int bad_cmd = 0;
    for (int i = 0; i < ROWW; i++)
      words[i] = (seed == 0) ? 24'hFFFFFF :
                 24'((seed * 32'h01F3A7) + (i * 32'h0B1C05)) ^ {8'(i), 16'h0};
    build_exp(a);
    rx_cnt = 0; bits = 0; width_err = 0; stab_err = 0; ready_err = 0;
    acc_cnt = 0; done_cnt = 0; done_wide = 0; done_rx = 0;
    @(negedge clk); start_addr = a; start = 1'b1;
    @(negedge clk); start = 1'b0;
    fork
      feed(stress);
      begin
        if (stress) begin
          repeat (3000) @(negedge clk);
          start_addr = ~a; start = 1'b1;
          @(negedge clk); start = 1'b0;
        end
      end
      begin
        while (done_cnt == 0) @(negedge clk);
      end
    join
    @(negedge clk);
    for (int i = 0; i < rx_cnt && i < NFR; i++) if (rx[i][3:0] != 4'h0) bad_cmd++;
    check(bad_cmd == 0, "R1 command nibble", bad_cmd, 0);
    region(0, 4, "R3 preamble");
    region(5, 7, "R4 address");
    grp_region(0, 5, "R5 packed moves");
    grp_region(6, 14, "R6 ptr clear and table writes");
    check(rx_cnt == NFR, "R7 frame count", rx_cnt, NFR);
    check(acc_cnt == ROWW, "R7 words accepted", acc_cnt, ROWW);
    region(248, 252, "R8 commit and pc reset");
    check(width_err == 0 && stab_err == 0, "R2 clock phases", width_err + stab_err, 0);
    check(ready_err == 0, "R9 ready while shifting", ready_err, 0);
    check(done_cnt == 1 && done_wide == 0, "R10 done pulse", done_cnt, 1);
    check(done_rx == NFR, "R10 done after last frame", done_rx, NFR);
    check(busy == 1'b0, "R10 idle after done", busy, 0);
    check(word_ready == 1'b0, "R9 ready idle", word_ready, 0);
  endtask

  task automatic t_reset;
    check(prog_clk == 1'b0 && prog_dat == 1'b0, "R2 reset idle lines", {prog_clk, prog_dat}, 0);
    check(word_ready == 1'b0, "R9 reset ready", word_ready, 0);
    check(busy == 1'b0 && done == 1'b0, "R10 reset status", {busy, done}, 0);
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; start_addr = '0; word_valid = 1'b0; word_data = '0;
    shreg = '0; hi_dat = 1'b0; hi_len = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_row(24'h012A00, 7, 1'b0);
    run_row(24'hFE7F80, 3, 1'b1);
    run_row(24'h000000, 0, 1'b0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule